// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Divider

This block divides one 32-bit IEEE-754 single-precision operand (A) by another (B) in a fixed pipeline. It takes one new operand pair on every enabled clock and hands out one packed quotient per enabled clock. There is no handshake. A result leaves the block fifteen enabled clock edges after its operands were sampled. Three flags travel with each quotient in the same cycle: overflow, underflow and invalid.

The pipeline has three parts. A classification stage decodes both operands into zero, normal, infinity or NaN. Subnormal operands are flushed to a signed zero. This stage also forms the result sign, the raw exponent and the first partial remainder. Thirteen recurrence stages follow. Each one produces two quotient bits by non-restoring division of the 24-bit significands. A final stage rounds to nearest-even, renormalises and packs the result. It maps out-of-range exponents and special operand classes to their fixed encodings.

When the enable input is low, every pipeline register holds its value. No operand pair in flight is lost. A synchronous active-high reset clears the whole pipeline, so the result and the flags read zero.

Top module: `fdiv_pipe`

## Requirements
- R1: For two normal operands whose quotient stays in the normal range, `quo` equals A/B rounded to nearest, ties to even, bit-exact. `ovf`, `unf` and `inv` are all 0.
- R2: An operand pair sampled on an enabled rising edge appears on `quo`/`ovf`/`unf`/`inv` after the 15th enabled rising edge, counting the edge that sampled it. Back-to-back pairs give back-to-back results.
- R3: While `en` is 0, no pipeline register changes. The outputs stay stable and the results in flight come out later in their original order.
- R4: While `rst` is 1 at a rising edge, `quo`, `ovf`, `unf` and `inv` become 0. The pipeline contents are also cleared, so the next 15 enabled results are 0 with no flags.
- R5: If either operand is a NaN (exponent field 255, fraction nonzero), or the pair is 0/0 or infinity/infinity, `quo` = 0x7FC00000 and `inv` = 1.
- R6: A finite nonzero A divided by a zero B, or an infinite A divided by a finite B, gives an infinity (exponent field 255, fraction 0) and no flag.
- R7: A zero A divided by a nonzero finite B, or a finite A divided by an infinite B, gives a zero (bits 30..0 equal 0) and no flag.
- R8: An operand with exponent field 0 is treated as a zero of the same sign, whatever its fraction.
- R9: If the rounded biased exponent of a normal-by-normal quotient is 255 or more, `quo` is an infinity (bits 30..0 = 0x7F800000) and `ovf` = 1.
- R10: If the rounded biased exponent of a normal-by-normal quotient is 0 or less, `quo` is a zero (bits 30..0 = 0) and `unf` = 1.
- R11: Except for the invalid case, bit 31 of `quo` is the XOR of the two operand sign bits (bit 31).
- R12: At most one of `ovf`, `unf` and `inv` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advances the pipeline when high; freezes it when low |
| opa | input | 32 | Dividend, IEEE-754 single precision |
| opb | input | 32 | Divisor, IEEE-754 single precision |
| quo | output | 32 | Packed quotient |
| ovf | output | 1 | Overflow flag for the quotient on `quo` |
| unf | output | 1 | Underflow flag for the quotient on `quo` |
| inv | output | 1 | Invalid-operation flag for the quotient on `quo` |

## Verification
A wrong bit in a partial remainder or a quotient register shows up as a wrong quotient significand or a misplaced rounding step. It reaches the ports within at most fourteen enabled cycles, on the one result that carried it. A class or exponent error in the front end appears on the same result as a wrong special encoding or a spurious flag. A fault in the enable gating breaks the alignment between operands and results. Every later result after the first frozen cycle then mismatches. The reference model therefore compares each output field on every clock, so a single corrupted result is caught in the cycle it emerges.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int EXP_W       = 8;
  localparam int FRAC_W      = 23;
  localparam int MANT_W      = FRAC_W + 1;
  localparam int BIAS        = 127;
  localparam int EXP_MAX     = (1 << EXP_W) - 1;
  localparam int CORE_STAGES = 13;
  localparam int BPS         = 2;
  localparam int QW          = 1 + CORE_STAGES * BPS;
  localparam int RW          = MANT_W + 3;
  localparam int XW          = EXP_W + 2;

  typedef enum logic [1:0] {
    K_ZERO = 2'd0,
    K_NORM = 2'd1,
    K_INF  = 2'd2,
    K_NAN  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e                  kind;
    logic                   sign;
    logic signed [XW-1:0]   exp;
    logic signed [RW-1:0]   rem;
    logic [QW-1:0]          q;
    logic [MANT_W-1:0]      divisor;
  } stage_t;
endpackage

// File: rtl/fdiv_classify.sv
module fdiv_classify
  import fdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  output stage_t      s_o
);
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic a_zero, a_inf, a_nan, b_zero, b_inf, b_nan;
  logic [MANT_W-1:0] ma, mb;
  logic signed [RW-1:0] r0;
  stage_t nxt;

  assign ea = opa[30:23];
  assign eb = opb[30:23];
  assign fa = opa[22:0];
  assign fb = opb[22:0];

  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == EXP_W'(EXP_MAX)) && (fa == '0);
  assign b_inf  = (eb == EXP_W'(EXP_MAX)) && (fb == '0);
  assign a_nan  = (ea == EXP_W'(EXP_MAX)) && (fa != '0);
  assign b_nan  = (eb == EXP_W'(EXP_MAX)) && (fb != '0);

  assign ma = {1'b1, fa};
  assign mb = {1'b1, fb};
  assign r0 = $signed({3'b000, ma}) - $signed({3'b000, mb});

  always_comb begin
    nxt         = '0;
    nxt.sign    = opa[31] ^ opb[31];
    nxt.exp     = $signed({2'b00, ea}) - $signed({2'b00, eb}) + XW'(BIAS);
    nxt.rem     = r0;
    nxt.q       = {{(QW-1){1'b0}}, ~r0[RW-1]};
    nxt.divisor = mb;
    if (a_nan || b_nan || (a_zero && b_zero) || (a_inf && b_inf))
      nxt.kind = K_NAN;
    else if (a_inf || b_zero)
      nxt.kind = K_INF;
    else if (a_zero || b_inf)
      nxt.kind = K_ZERO;
    else
      nxt.kind = K_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst)     s_o <= '0;
    else if (en) s_o <= nxt;
  end

  // R5: a NaN operand always yields the invalid class one stage later
  p_nan_class_r5: assert property (@(posedge clk) disable iff (rst)
    (en && (a_nan || b_nan)) |=> (s_o.kind == K_NAN));
endmodule

// File: rtl/fdiv_core_stage.sv
module fdiv_core_stage
  import fdiv_pkg::*;
#(
  parameter int STEPS = BPS
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  stage_t s_i,
  output stage_t s_o
);
  stage_t nxt;
  logic signed [RW-1:0] d_i, d_o;

  assign d_i = $signed({3'b000, s_i.divisor});
  assign d_o = $signed({3'b000, s_o.divisor});

  always_comb begin
    logic signed [RW-1:0] r;
    logic [QW-1:0]        q;
    r = s_i.rem;
    q = s_i.q;
    for (int k = 0; k < STEPS; k++) begin
      if (!r[RW-1]) r = {r[RW-2:0], 1'b0} - d_i;
      else          r = {r[RW-2:0], 1'b0} + d_i;
      q = {q[QW-2:0], ~r[RW-1]};
    end
    nxt     = s_i;
    nxt.rem = r;
    nxt.q   = q;
  end

  always_ff @(posedge clk) begin
    if (rst)     s_o <= '0;
    else if (en) s_o <= nxt;
  end

  // R1: the partial remainder of a live division stays in [-d, d)
  p_rem_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (s_o.kind == K_NORM) |-> ((s_o.rem < d_o) && (s_o.rem >= -d_o)));
endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack
  import fdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  stage_t      s_i,
  output logic [31:0] quo,
  output logic        ovf,
  output logic        unf,
  output logic        inv
);
  logic signed [RW-1:0] d, tr;
  logic                 rem_nz, hi, g, st, up;
  logic [MANT_W-1:0]    mant, mfin;
  logic [MANT_W:0]      m25;
  logic signed [XW:0]   e_w;
  logic [31:0]          quo_n;
  logic                 ovf_n, unf_n, inv_n;

  assign d      = $signed({3'b000, s_i.divisor});
  assign tr     = s_i.rem[RW-1] ? (s_i.rem + d) : s_i.rem;
  assign rem_nz = (tr != '0);
  assign hi     = s_i.q[QW-1];

  always_comb begin
    if (hi) begin
      mant = s_i.q[QW-1 -: MANT_W];
      g    = s_i.q[QW-1-MANT_W];
      st   = (|s_i.q[QW-2-MANT_W:0]) | rem_nz;
    end else begin
      mant = s_i.q[QW-2 -: MANT_W];
      g    = s_i.q[QW-2-MANT_W];
      st   = (|s_i.q[QW-3-MANT_W:0]) | rem_nz;
    end
  end

  assign up   = g & (st | mant[0]);
  assign m25  = {1'b0, mant} + {{MANT_W{1'b0}}, up};
  assign mfin = m25[MANT_W] ? m25[MANT_W:1] : m25[MANT_W-1:0];
  assign e_w  = {s_i.exp[XW-1], s_i.exp} - {{XW{1'b0}}, ~hi}
              + {{XW{1'b0}}, m25[MANT_W]};

  always_comb begin
    quo_n = '0;
    ovf_n = 1'b0;
    unf_n = 1'b0;
    inv_n = 1'b0;
    case (s_i.kind)
      K_NAN: begin
        quo_n = 32'h7FC0_0000;
        inv_n = 1'b1;
      end
      K_INF:  quo_n = {s_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      K_ZERO: quo_n = {s_i.sign, 31'd0};
      default: begin
        if (e_w >= (XW+1)'(EXP_MAX)) begin
          quo_n = {s_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf_n = 1'b1;
        end else if (e_w <= (XW+1)'(0)) begin
          quo_n = {s_i.sign, 31'd0};
          unf_n = 1'b1;
        end else begin
          quo_n = {s_i.sign, e_w[EXP_W-1:0], mfin[FRAC_W-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
      inv <= 1'b0;
    end else if (en) begin
      quo <= quo_n;
      ovf <= ovf_n;
      unf <= unf_n;
      inv <= inv_n;
    end
  end

  // R12: flags are mutually exclusive
  p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf, unf, inv}));
  // R5: invalid always comes with the canonical quiet NaN
  p_invalid_qnan_r5: assert property (@(posedge clk) disable iff (rst)
    inv |-> (quo == 32'h7FC0_0000));
  // R9: overflow always comes with an infinity
  p_overflow_inf_r9: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (quo[30:0] == 31'h7F80_0000));
  // R10: underflow always comes with a zero
  p_underflow_zero_r10: assert property (@(posedge clk) disable iff (rst)
    unf |-> (quo[30:0] == 31'd0));
endmodule

// File: rtl/fdiv_pipe.sv
module fdiv_pipe
  import fdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  output logic [31:0] quo,
  output logic        ovf,
  output logic        unf,
  output logic        inv
);
  stage_t chain [0:CORE_STAGES];

  fdiv_classify u_classify (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .opa (opa),
    .opb (opb),
    .s_o (chain[0])
  );

  for (genvar gi = 0; gi < CORE_STAGES; gi++) begin : g_core
    fdiv_core_stage #(.STEPS(BPS)) u_stage (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .s_i (chain[gi]),
      .s_o (chain[gi+1])
    );
  end

  fdiv_pack u_pack (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .s_i (chain[CORE_STAGES]),
    .quo (quo),
    .ovf (ovf),
    .unf (unf),
    .inv (inv)
  );

  // R3: with enable low the visible result does not move
  p_freeze_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(quo) && $stable(ovf) && $stable(unf) && $stable(inv)));
  // R4: reset clears the outputs on the following cycle
  p_reset_clear_r4: assert property (@(posedge clk)
    rst |=> (quo == '0 && !ovf && !unf && !inv));
endmodule

// File: tb/fdiv_pipe_tb_top.sv
`timescale 1ns/1ps
module fdiv_pipe_tb_top;
  localparam int LAT = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] quo;
  logic        ovf, unf, inv;

  int checks = 0;
  int fails  = 0;
  bit checking = 1'b0;
  logic [38:0] model [LAT];

  always #4 clk = ~clk;

  fdiv_pipe dut_i (
    .clk (clk), .rst (rst), .en (en), .opa (opa), .opb (opb),
    .quo (quo), .ovf (ovf), .unf (unf), .inv (inv)
  );

  // Tag codes: 0 reset bubble, else requirement number
  function automatic string tagname(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R4";
    endcase
  endfunction

  // Returns {tag[3:0], ovf, unf, inv, result[31:0]}
  function automatic logic [38:0] ref_div(input logic [31:0] a, input logic [31:0] b);
    int ea, eb, e;
    longint fa, fb, ma, mb, num, q, rem, mant;
    bit az, bz, ai, bi, an, bn, sub, sg, g, s, up;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = longint'(a[22:0]); fb = longint'(b[22:0]);
    sg = a[31] ^ b[31];
    az = (ea == 0); bz = (eb == 0);
    ai = (ea == 255) && (fa == 0); bi = (eb == 255) && (fb == 0);
    an = (ea == 255) && (fa != 0); bn = (eb == 255) && (fb != 0);
    sub = (az && fa != 0) || (bz && fb != 0);
    if (an || bn || (az && bz) || (ai && bi))
      return {4'd5, 3'b001, 32'h7FC0_0000};
    if (ai || bz)
      return {(sub ? 4'd8 : 4'd6), 3'b000, sg, 8'hFF, 23'd0};
    if (az || bi)
      return {(sub ? 4'd8 : 4'd7), 3'b000, sg, 31'd0};
    ma = fa + 64'sd8388608; mb = fb + 64'sd8388608;
    num = ma * 64'sd67108864;
    q = num / mb; rem = num % mb;
    e = ea - eb + 127;
    if (q >= 64'sd67108864) begin
      mant = q / 8; g = ((q / 4) % 2) != 0; s = ((q % 4) != 0) || (rem != 0);
    end else begin
      e = e - 1;
      mant = q / 4; g = ((q / 2) % 2) != 0; s = ((q % 2) != 0) || (rem != 0);
    end
    up = g && (s || (mant % 2 != 0));
    if (up) mant = mant + 1;
    if (mant == 64'sd16777216) begin mant = 64'sd8388608; e = e + 1; end
    if (e >= 255) return {4'd9, 3'b100, sg, 8'hFF, 23'd0};
    if (e <= 0)   return {4'd10, 3'b010, sg, 31'd0};
    return {4'd1, 3'b000, sg, e[7:0], mant[22:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) model[i] <= '0;
    end else if (en) begin
      model[0] <= ref_div(opa, opb);
      for (int i = 1; i < LAT; i++) model[i] <= model[i-1];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      logic [38:0] m;
      m = model[LAT-1];
      // R2 alignment of the stream, with the case's own requirement
      chk(quo[30:0] == m[30:0], {"R2 ", tagname(m[38:35])}, quo, m[31:0]);
      chk({ovf, unf, inv} == m[34:32], {"R2 flags ", tagname(m[38:35])},
          {29'd0, ovf, unf, inv}, {29'd0, m[34:32]});
      if (m[32] == 1'b0)
        chk(quo[31] == m[31], "R11 sign", {31'd0, quo[31]}, {31'd0, m[31]});
      chk($onehot0({ovf, unf, inv}), "R12 flags", {29'd0, ovf, unf, inv}, 32'd0);
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opa = a; opb = b; en = 1'b1;
  endtask

  logic [31:0] lfsr = 32'h1234_5678;
  function automatic logic [31:0] nxt_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R4: outputs cleared during reset
    chk(quo == 32'd0, "R4 quo", quo, 32'd0);
    chk({ovf, unf, inv} == 3'b000, "R4 flags", {29'd0, ovf, unf, inv}, 32'd0);
    rst = 1'b0;
    checking = 1'b1;
    en = 1'b1;
    // R1 normal quotients
    send(32'h3F80_0000, 32'h4040_0000);
    send(32'h40C0_0000, 32'h4000_0000);
    send(32'h3FC0_0000, 32'h3FA0_0000);
    send(32'hC120_0000, 32'h4040_0000);
    send(32'h3F7F_FFFF, 32'h3F7F_FFFE);
    send(32'h0080_0000, 32'h3F80_0000);
    send(32'h7F7F_FFFF, 32'h3F80_0000);
    // R5 invalid cases
    send(32'h0000_0000, 32'h8000_0000);
    send(32'h7F80_0000, 32'hFF80_0000);
    send(32'h7F80_0001, 32'h3F80_0000);
    send(32'h3F80_0000, 32'hFFC0_0000);
    // R6 infinities
    send(32'h3F80_0000, 32'h8000_0000);
    send(32'hFF80_0000, 32'h4000_0000);
    // R7 zeros
    send(32'h4000_0000, 32'h7F80_0000);
    send(32'h8000_0000, 32'h40A0_0000);
    // R8 subnormals as zero
    send(32'h0000_0001, 32'h3F80_0000);
    send(32'h3F80_0000, 32'h807F_FFFF);
    // R9 overflow and R10 underflow
    send(32'h7F7F_FFFF, 32'h3E80_0000);
    send(32'hFF00_0000, 32'h3F00_0000);
    send(32'h0080_0000, 32'h4000_0000);
    send(32'h8100_0000, 32'h7E80_0000);
    // R3: freeze with results in flight, outputs must hold
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    begin
      logic [31:0] hold;
      hold = quo;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(quo == hold, "R3 hold", quo, hold);
      end
    end
    // random stream with occasional stalls
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      lfsr = nxt_rand(lfsr); a = lfsr;
      lfsr = nxt_rand(lfsr); b = lfsr;
      if (lfsr[9:8] != 2'b00) begin
        a[30:23] = 8'(100 + int'(a[28:23]) % 56);
        b[30:23] = 8'(100 + int'(b[28:23]) % 56);
      end
      @(negedge clk);
      opa = a; opb = b;
      en = (lfsr[14:12] != 3'b000);
    end
    @(negedge clk);
    en = 1'b1;
    repeat (LAT + 2) @(negedge clk);
    checking = 1'b0;
    summary();
    $finish;
  end

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule